// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

This block is the host side of a write-only three-wire link to a 16-bit voltage-output converter. A client offers a command on a valid/ready handshake: a 16-bit output code and a 2-bit power-down selection. The block serialises the command into one 24-bit frame on an active-low frame strobe (`frm_n`), a serial clock (`ser_clk`) and a data line (`ser_dat`). The receiver samples data on the falling edge of `ser_clk`, so the block moves `ser_dat` only on rising edges. `ser_clk` is low whenever the strobe is inactive.

All serial timing is counted in system clocks. The high and low phases of `ser_clk`, the delay from strobe assertion to the first sampling edge, and the minimum inactive time of the strobe between frames are all derived at elaboration from the system clock period and the nanosecond limits of the receiver. The block raises `done` once per frame and holds `busy` while a frame is in flight.

The `IDLE_LOW` parameter lowers receiver power. With it set, the strobe stays low once a frame has finished, and the block drives it high for the minimum inactive time just before the next frame starts.

Top module: `dac_frame_tx`

## Requirements
- R1: While reset is asserted, and after it is released with no command offered, `frm_n`=1, `ser_clk`=0, `cmd_ready`=1, `busy`=0 and `done`=0.
- R2: A frame carries 24 bits, most significant first: six zero bits, then `cmd_mode[1]`, `cmd_mode[0]`, then `cmd_code[15]` down to `cmd_code[0]`. The receiver captures one bit on each falling edge of `ser_clk` while `frm_n` is low.
- R3: While `frm_n` is low, `ser_dat` changes only in the cycle in which `ser_clk` rises. It is therefore unchanged across every falling edge.
- R4: Within a frame, each high phase and each low phase of `ser_clk` lasts exactly HALF_CYC system clocks. HALF_CYC is the larger of ceil(33 ns / 2 / Tclk) and ceil(13 ns / Tclk), which is 4 at 5 ns. `ser_clk` is 0 whenever `frm_n` is 1.
- R5: `frm_n` stays low without interruption for 24 falling edges of `ser_clk`. The first rising edge of `ser_clk` comes SETUP_CYC = ceil(13 ns / Tclk) cycles after `frm_n` falls.
- R6: With `IDLE_LOW`=0, `frm_n` rises HALF_CYC cycles after the 24th falling edge. It stays high for at least GAP_CYC = ceil(33 ns / Tclk) cycles before the next frame, and `cmd_ready` returns only after that gap.
- R7: `done` is high for exactly one cycle per frame. That cycle is the first one in which `ser_clk` is low after the 24th high phase.
- R8: A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is low from the accept until the frame ends. Changes on the command inputs while busy do not alter the frame being sent.
- R9: With `IDLE_LOW`=1, `frm_n` remains low after a frame and `cmd_ready` returns while it is low. An accepted command first drives `frm_n` high for exactly GAP_CYC cycles, then low to start the frame.
- R10: `busy` is the complement of `cmd_ready`. It stays high for exactly SETUP_CYC + GAP_CYC + 48·HALF_CYC cycles per command, which is 202 at 5 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block is idle and takes the command this cycle |
| cmd_code | input | 16 | Output code to send |
| cmd_mode | input | 2 | Power-down selection field (00 run, other values select a power-down load) |
| busy | output | 1 | A frame or its surrounding gap is in progress |
| done | output | 1 | One-cycle pulse after the last sampling edge |
| frm_n | output | 1 | Active-low frame strobe |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_dat | output | 1 | Serial data, MSB first |

## Verification
The properties assume the design starts from reset with the strobe high. They do not assume that the client behaves in any particular way. `cmd_valid` may stay high while the block is busy, and the command inputs may change at any cycle without affecting any property.

The gap property ignores the first falling edge of the strobe after reset, because the time before reset is not bounded. The stimulus always waits well past GAP_CYC after reset before offering the first command.

The stimulus drives inputs one nanosecond after a rising edge. It alternates between frames sent back-to-back with `cmd_valid` held high and frames where the command inputs are scrambled right after the accept. This exercises both the handshake and the capture of the command.

// File: rtl/dac_frame_pkg.sv
`timescale 1ns/1ps
package dac_frame_pkg;

  // sequencer states of the frame transmitter
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP
  } fsm_state_t;

  // power-down selection carried in the frame, passed through unchanged
  typedef enum logic [1:0] {
    PD_RUN       = 2'b00,
    PD_LOAD_1K   = 2'b01,
    PD_LOAD_100K = 2'b10,
    PD_OPEN      = 2'b11
  } pd_sel_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_frame_timer.sv
`timescale 1ns/1ps
module dac_frame_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign expired = (cnt_q == '0);

  always_comb begin
    cnt_en = load | ~expired;
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dac_frame_shifter.sv
`timescale 1ns/1ps
module dac_frame_shifter #(
  parameter int PAD_W  = 6,
  parameter int MODE_W = 2,
  parameter int CODE_W = 16,
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [MODE_W-1:0] mode,
  input  logic [CODE_W-1:0] code,
  output logic              msb
);

  logic [FRAME_W-1:0] sr_q;
  logic [FRAME_W-1:0] sr_d;
  logic               sr_en;

  assign msb = sr_q[FRAME_W-1];

  always_comb begin
    sr_en = load | shift;
    if (load) begin
      sr_d = {{PAD_W{1'b0}}, mode, code};
    end else begin
      sr_d = {sr_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sr_en) begin
      sr_q <= sr_d;
    end
  end

endmodule

// File: rtl/dac_frame_ctrl.sv
`timescale 1ns/1ps
module dac_frame_ctrl
  import dac_frame_pkg::*;
#(
  parameter int FRAME_W   = 24,
  parameter int CNT_W     = 3,
  parameter int HALF_CYC  = 4,
  parameter int SETUP_CYC = 3,
  parameter int GAP_CYC   = 7,
  parameter bit IDLE_LOW  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             expired,
  output logic             cmd_ready,
  output logic             busy,
  output logic             done,
  output logic             frm_n,
  output logic             ser_clk,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             sh_load,
  output logic             sh_shift
);

  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] HALF_LD   = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD    = CNT_W'(GAP_CYC - 1);

  fsm_state_t       state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             frm_q, frm_d;
  logic             sclk_q, sclk_d;
  logic             done_q, done_d;
  logic             last_bit;

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = ~cmd_ready;
  assign done      = done_q;
  assign frm_n     = frm_q;
  assign ser_clk   = sclk_q;
  assign last_bit  = (bit_q == LAST_BIT);

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    frm_d    = frm_q;
    sclk_d   = sclk_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          sh_load  = 1'b1;
          bit_d    = '0;
          tmr_load = 1'b1;
          if (IDLE_LOW) begin
            state_d = ST_PRE;
            frm_d   = 1'b1;
            tmr_val = GAP_LD;
          end else begin
            state_d = ST_SETUP;
            frm_d   = 1'b0;
            tmr_val = SETUP_LD;
          end
        end
      end
      ST_PRE: begin
        if (expired) begin
          state_d  = ST_SETUP;
          frm_d    = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = SETUP_LD;
        end
      end
      ST_SETUP: begin
        if (expired) begin
          state_d  = ST_HIGH;
          sclk_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = HALF_LD;
        end
      end
      ST_HIGH: begin
        if (expired) begin
          state_d  = ST_LOW;
          sclk_d   = 1'b0;
          done_d   = last_bit;
          tmr_load = 1'b1;
          tmr_val  = HALF_LD;
        end
      end
      ST_LOW: begin
        if (expired) begin
          if (last_bit) begin
            if (IDLE_LOW) begin
              state_d = ST_IDLE;
            end else begin
              state_d  = ST_GAP;
              frm_d    = 1'b1;
              tmr_load = 1'b1;
              tmr_val  = GAP_LD;
            end
          end else begin
            state_d  = ST_HIGH;
            sclk_d   = 1'b1;
            sh_shift = 1'b1;
            bit_d    = bit_q + 1'b1;
            tmr_load = 1'b1;
            tmr_val  = HALF_LD;
          end
        end
      end
      ST_GAP: begin
        if (expired) begin
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        frm_d   = 1'b1;
        sclk_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      frm_q   <= 1'b1;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      frm_q   <= frm_d;
      sclk_q  <= sclk_d;
      done_q  <= done_d;
    end
  end

endmodule

// File: rtl/dac_frame_tx.sv
`timescale 1ns/1ps
module dac_frame_tx
  import dac_frame_pkg::*;
#(
  parameter int CODE_W        = 16,
  parameter int MODE_W        = 2,
  parameter int PAD_W         = 6,
  parameter int CLK_PERIOD_PS = 5000,
  parameter int MIN_PERIOD_PS = 33000,
  parameter int MIN_PULSE_PS  = 13000,
  parameter int MIN_SETUP_PS  = 13000,
  parameter int MIN_GAP_PS    = 33000,
  parameter bit IDLE_LOW      = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic [MODE_W-1:0] cmd_mode,
  output logic              busy,
  output logic              done,
  output logic              frm_n,
  output logic              ser_clk,
  output logic              ser_dat
);

  localparam int FRAME_W   = PAD_W + MODE_W + CODE_W;
  localparam int HALF_CYC  = max_int(ceil_div(MIN_PERIOD_PS, 2 * CLK_PERIOD_PS),
                                     max_int(ceil_div(MIN_PULSE_PS, CLK_PERIOD_PS), 1));
  localparam int SETUP_CYC = max_int(ceil_div(MIN_SETUP_PS, CLK_PERIOD_PS), 1);
  localparam int GAP_CYC   = max_int(ceil_div(MIN_GAP_PS, CLK_PERIOD_PS), 1);
  localparam int MAX_CYC   = max_int(HALF_CYC, max_int(SETUP_CYC, GAP_CYC));
  localparam int CNT_W     = max_int($clog2(MAX_CYC), 1);

  logic [1:0]       rst_pipe_q;
  logic             rst_core_n;
  logic             expired;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             sh_load;
  logic             sh_shift;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  dac_frame_ctrl #(
    .FRAME_W   (FRAME_W),
    .CNT_W     (CNT_W),
    .HALF_CYC  (HALF_CYC),
    .SETUP_CYC (SETUP_CYC),
    .GAP_CYC   (GAP_CYC),
    .IDLE_LOW  (IDLE_LOW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cmd_valid (cmd_valid),
    .expired   (expired),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .done      (done),
    .frm_n     (frm_n),
    .ser_clk   (ser_clk),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .sh_load   (sh_load),
    .sh_shift  (sh_shift)
  );

  dac_frame_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (expired)
  );

  dac_frame_shifter #(
    .PAD_W  (PAD_W),
    .MODE_W (MODE_W),
    .CODE_W (CODE_W)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_core_n),
    .load  (sh_load),
    .shift (sh_shift),
    .mode  (cmd_mode),
    .code  (cmd_code),
    .msb   (ser_dat)
  );

endmodule

// File: rtl/dac_frame_tx_chk.sv
`timescale 1ns/1ps
module dac_frame_tx_chk #(
  parameter int FRAME_W  = 24,
  parameter int HALF_CYC = 4,
  parameter int GAP_CYC  = 7
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic frm_n,
  input logic ser_clk,
  input logic ser_dat
);

  localparam int EW = $clog2(FRAME_W + 1) + 1;
  localparam int HW = $clog2(HALF_CYC + 1) + 1;
  localparam int GW = $clog2(GAP_CYC + 1) + 1;

  logic          sclk_d;
  logic [EW-1:0] fall_cnt;
  logic [HW-1:0] clk_hi_cnt;
  logic [GW-1:0] frm_hi_cnt;
  logic          seen_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b0;
      fall_cnt   <= '0;
      clk_hi_cnt <= '0;
      frm_hi_cnt <= '0;
      seen_low   <= 1'b0;
    end else begin
      sclk_d <= ser_clk;
      if (frm_n) begin
        fall_cnt <= '0;
      end else if (sclk_d && !ser_clk) begin
        fall_cnt <= fall_cnt + 1'b1;
      end
      if (!ser_clk) begin
        clk_hi_cnt <= '0;
      end else if (clk_hi_cnt != '1) begin
        clk_hi_cnt <= clk_hi_cnt + 1'b1;
      end
      if (!frm_n) begin
        frm_hi_cnt <= '0;
        seen_low   <= 1'b1;
      end else if (frm_hi_cnt < GW'(GAP_CYC)) begin
        frm_hi_cnt <= frm_hi_cnt + 1'b1;
      end
    end
  end

  AST_CLK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frm_n |-> !ser_clk); // R4
  AST_HIGH_PHASE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (clk_hi_cnt == HW'(HALF_CYC))); // R4
  AST_DATA_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!frm_n && $past(!frm_n) && !$rose(ser_clk)) |-> $stable(ser_dat)); // R3
  AST_FRAME_UNBROKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_n) |-> (fall_cnt == EW'(FRAME_W))); // R5
  AST_GAP_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frm_n) && seen_low) |-> (frm_hi_cnt >= GW'(GAP_CYC))); // R6
  AST_DONE_AT_LAST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($fell(ser_clk) && fall_cnt == EW'(FRAME_W - 1))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready)); // R8

endmodule

bind dac_frame_tx dac_frame_tx_chk #(
  .FRAME_W  (FRAME_W),
  .HALF_CYC (HALF_CYC),
  .GAP_CYC  (GAP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .done      (done),
  .frm_n     (frm_n),
  .ser_clk   (ser_clk),
  .ser_dat   (ser_dat)
);

// File: tb/dac_frame_tx_tb.sv
`timescale 1ns/1ps
module dac_frame_mon #(
  parameter int HALF     = 4,
  parameter int SETUP    = 3,
  parameter int GAP      = 7,
  parameter bit IDLE_LOW = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic        cmd_ready,
  input  logic [15:0] cmd_code,
  input  logic [1:0]  cmd_mode,
  input  logic        busy,
  input  logic        done,
  input  logic        frm_n,
  input  logic        ser_clk,
  input  logic        ser_dat,
  output int          n_chk,
  output int          n_err,
  output int          frames
);

  localparam int BUSY_LEN = SETUP + GAP + 48 * HALF;

  logic        p_clk, p_frm, p_dat, p_rdy, p_done;
  logic [23:0] word, expw;
  int          hi_c, lo_c, falls, frm_hi, busy_c;
  bit          stray, clk_idle_bad;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s (idle_low=%0d) actual=%0d expected=%0d", tag, IDLE_LOW, act, exp);
    end
  endtask

  initial begin
    n_chk = 0; n_err = 0; frames = 0;
    p_clk = 0; p_frm = 1; p_dat = 0; p_rdy = 1; p_done = 0;
    word = '0; expw = '0; hi_c = 0; lo_c = 0; falls = 0; frm_hi = 0; busy_c = 0;
    stray = 0; clk_idle_bad = 0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid && cmd_ready) expw = {6'b000000, cmd_mode, cmd_code};
      if (busy) busy_c++;
      if (frm_n && ser_clk) clk_idle_bad = 1;
      if (p_frm && !frm_n) begin
        if (frames > 0) begin
          if (IDLE_LOW) chk(frm_hi == GAP, "R9 strobe pulse length", frm_hi, GAP);
          else          chk(frm_hi >= GAP, "R6 strobe gap", frm_hi, GAP);
        end
        chk(!clk_idle_bad, "R4 clock low while strobe high", clk_idle_bad, 0);
        clk_idle_bad = 0;
        falls = 0; lo_c = 0; stray = 0; frm_hi = 0;
      end
      if (frm_n) frm_hi++;
      if (!frm_n) begin
        if (p_clk && !ser_clk) begin
          chk(hi_c == HALF, "R4 high phase", hi_c, HALF);
          chk(ser_dat == p_dat, "R3 data at falling edge", ser_dat, p_dat);
          word = {word[22:0], ser_dat};
          falls++;
          lo_c = 1;
        end else if (!p_clk && ser_clk) begin
          if (falls == 0) chk(lo_c == SETUP, "R5 setup before first rise", lo_c, SETUP);
          else            chk(lo_c == HALF, "R4 low phase", lo_c, HALF);
          hi_c = 1;
        end else begin
          if (ser_clk) hi_c++; else lo_c++;
          if (!p_frm && ser_dat != p_dat) stray = 1;
        end
      end
      if (done) begin
        chk(falls == 24 && p_clk && !ser_clk, "R7 done placement", falls, 24);
        chk(!p_done, "R7 done single cycle", p_done, 0);
        chk(word == expw, "R2 R8 frame content", int'(word), int'(expw));
        chk(!stray, "R3 data moved off rising edge", stray, 0);
        chk(busy && !cmd_ready, "R10 busy during frame", busy, 1);
        chk(!frm_n, "R5 strobe low at last edge", frm_n, 0);
        frames++;
      end
      if (!p_rdy && cmd_ready) begin
        chk(busy_c == BUSY_LEN, "R10 busy length", busy_c, BUSY_LEN);
        chk(!busy, "R10 busy clears with ready", busy, 0);
        if (IDLE_LOW) chk(frm_n == 1'b0, "R9 strobe idles low", frm_n, 0);
        else          chk(frm_n == 1'b1 && frm_hi >= GAP, "R6 ready after gap", frm_hi, GAP);
        busy_c = 0;
      end
      p_clk = ser_clk; p_frm = frm_n; p_dat = ser_dat; p_rdy = cmd_ready; p_done = done;
    end
  end

endmodule

module dac_frame_tx_tb;

  localparam int TCLK_PS  = 5000;
  localparam int HALF_E   = 4;   // max(ceil(16500/5000), ceil(13000/5000))
  localparam int SETUP_E  = 3;   // ceil(13000/5000)
  localparam int GAP_E    = 7;   // ceil(33000/5000)
  localparam int N_CODES  = 22;
  localparam int N_FRAMES = 4 * N_CODES;

  logic        clk;
  logic        rst_n;
  logic        v    [2];
  logic [15:0] code [2];
  logic [1:0]  mode [2];
  logic        rdy  [2];
  logic        bsy  [2];
  logic        dn   [2];
  logic        sc   [2];
  logic        sd   [2];
  logic        fn   [2];
  int          mchk [2];
  int          merr [2];
  int          mfrm [2];
  int          n_chk, n_err;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  dac_frame_tx #(.CLK_PERIOD_PS(TCLK_PS), .IDLE_LOW(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(v[0]), .cmd_ready(rdy[0]),
    .cmd_code(code[0]), .cmd_mode(mode[0]), .busy(bsy[0]), .done(dn[0]),
    .frm_n(fn[0]), .ser_clk(sc[0]), .ser_dat(sd[0]));

  dac_frame_tx #(.CLK_PERIOD_PS(TCLK_PS), .IDLE_LOW(1'b1)) u_dut_lo (
    .clk(clk), .rst_n(rst_n), .cmd_valid(v[1]), .cmd_ready(rdy[1]),
    .cmd_code(code[1]), .cmd_mode(mode[1]), .busy(bsy[1]), .done(dn[1]),
    .frm_n(fn[1]), .ser_clk(sc[1]), .ser_dat(sd[1]));

  dac_frame_mon #(.HALF(HALF_E), .SETUP(SETUP_E), .GAP(GAP_E), .IDLE_LOW(1'b0)) u_mon0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(v[0]), .cmd_ready(rdy[0]), .cmd_code(code[0]),
    .cmd_mode(mode[0]), .busy(bsy[0]), .done(dn[0]), .frm_n(fn[0]), .ser_clk(sc[0]),
    .ser_dat(sd[0]), .n_chk(mchk[0]), .n_err(merr[0]), .frames(mfrm[0]));

  dac_frame_mon #(.HALF(HALF_E), .SETUP(SETUP_E), .GAP(GAP_E), .IDLE_LOW(1'b1)) u_mon1 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(v[1]), .cmd_ready(rdy[1]), .cmd_code(code[1]),
    .cmd_mode(mode[1]), .busy(bsy[1]), .done(dn[1]), .frm_n(fn[1]), .ser_clk(sc[1]),
    .ser_dat(sd[1]), .n_chk(mchk[1]), .n_err(merr[1]), .frames(mfrm[1]));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk + mchk[0] + mchk[1], n_err + merr[0] + merr[1]);
  endtask

  function automatic logic [15:0] code_of(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      4: return 16'hAAAA;
      5: return 16'h5555;
      default: return 16'h0001 << (i - 6);
    endcase
  endfunction

  task automatic check_idle(input int k, input string tag);
    check(fn[k] == 1'b1, {tag, " frm_n"}, fn[k], 1);
    check(sc[k] == 1'b0, {tag, " ser_clk"}, sc[k], 0);
    check(rdy[k] == 1'b1 && bsy[k] == 1'b0, {tag, " ready/busy"}, rdy[k], 1);
    check(dn[k] == 1'b0, {tag, " done"}, dn[k], 0);
  endtask

  task automatic send(input int k, input logic [15:0] c, input logic [1:0] m, input bit keep);
    @(posedge clk); #1;
    v[k] = 1'b1; code[k] = c; mode[k] = m;
    @(negedge clk);
    while (!rdy[k]) @(negedge clk);
    @(posedge clk); #1;
    if (!keep) begin
      v[k] = 1'b0; code[k] = ~c; mode[k] = ~m;
    end
    @(negedge clk);
    check(rdy[k] == 1'b0 && bsy[k] == 1'b1, "R8 ready drops after accept", rdy[k], 0);
  endtask

  task automatic run(input int k);
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < N_CODES; i++) begin
        send(k, code_of(i), 2'(m), ((m * N_CODES + i) % 2 == 0));
      end
    end
    @(negedge clk);
    while (!rdy[k]) @(negedge clk);
    repeat (12) @(negedge clk);
    check(mfrm[k] == N_FRAMES, "R7 one done per command", mfrm[k], N_FRAMES);
  endtask

  initial begin
    n_chk = 0; n_err = 0;
    rst_n = 1'b0;
    for (int k = 0; k < 2; k++) begin
      v[k] = 1'b0; code[k] = '0; mode[k] = '0;
    end
    repeat (4) @(negedge clk);
    check_idle(0, "R1 in reset");
    check_idle(1, "R1 in reset (idle-low)");
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    check_idle(0, "R1 after release");
    check_idle(1, "R1 after release (idle-low)");
    fork
      run(0);
      run(1);
    join
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R10 run did not finish actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

endmodule